// File: doc/BRIEF.md
# Control-Transfer Resolution Unit

This block resolves control-transfer instructions for a 32-bit pipelined core. Each cycle it can take one instruction word. With the word come the values of the two registers to compare, the address of the instruction, and the direction and target the front end predicted. It finds out whether the transfer is really taken and where it really goes. It gives the address of the next instruction, and it raises a misprediction flag with a corrected address so the front end can redirect fetch.

It handles four conditional branches (equal, not equal, signed less-than, signed greater-than) and one absolute jump. A branch target is the address after the instruction plus a word-scaled, sign-extended 16-bit offset. A jump target is its 26-bit field scaled to words, with zeros above it. Each result also carries the resolved address, direction and target, so the predictor can be trained from the same record. Results appear one clock after the instruction is accepted.

Top module: `branch_resolve_unit`

## Requirements
- R1: The opcode is instruction bits [31:26]. The value 100000 selects branch-if-equal, 100001 branch-if-not-equal, 100010 branch-if-less, 100011 branch-if-greater, and 100100 jump. A valid input with any other opcode produces no result: out_valid stays low in the following cycle.
- R2: An accepted instruction gives exactly one result with out_valid high, in the cycle after in_valid was sampled. A cycle with no accepted instruction leaves out_valid low. While rst_n is low, out_valid is low.
- R3: Equal and not-equal compare in_opa (the first register field, bits [25:21]) with in_opb (the second register field, bits [20:16]) over all 32 bits.
- R4: Less-than is taken when in_opa < in_opb as signed two's-complement values. Greater-than is taken when in_opa > in_opb as signed values.
- R5: The target of a branch is in_pc + 4 + 4*sext(bits [15:0]), with wrap-around modulo 2^32. A negative offset gives a backward target.
- R6: A jump is always taken. Its target is {4'b0000, bits [25:0], 2'b00}.
- R7: out_next_pc equals out_target when the result is taken and out_pc + 4 when it is not.
- R8: out_mispredict is high when the resolved direction differs from in_pred_taken.
- R9: When both the prediction and the result say taken, out_mispredict is high exactly when in_pred_target differs from the real target. A correctly predicted not-taken result never mispredicts, whatever the predicted target is.
- R10: out_redirect_pc equals out_next_pc when out_mispredict is high, and is zero otherwise.
- R11: The result record gives the instruction's own address on out_pc. out_target holds the computed target even when the branch is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_instr | input | 32 | Instruction word |
| in_pc | input | 32 | Address of the instruction |
| in_opa | input | 32 | Value of the first register field |
| in_opb | input | 32 | Value of the second register field |
| in_pred_taken | input | 1 | Predicted direction |
| in_pred_target | input | 32 | Predicted target |
| out_valid | output | 1 | Result valid |
| out_pc | output | 32 | Address of the resolved instruction |
| out_taken | output | 1 | Resolved direction |
| out_target | output | 32 | Computed target |
| out_next_pc | output | 32 | Real next address |
| out_mispredict | output | 1 | Prediction was wrong |
| out_redirect_pc | output | 32 | Corrected fetch address, zero if none |

## Verification
Two checks can fire on the same instruction: the direction check and the target check. The bench sets them up on purpose. One case is a prediction of taken with a wrong target on a branch that turns out not taken. The other is a prediction of taken with a wrong target on a branch that really is taken. In the first case the redirect must point to the next sequential address, not to either target. In the second case the redirect must point to the real target. Both cases must raise a single mispredict flag in that one result cycle. A correctly predicted not-taken branch whose predicted target is garbage must raise nothing.

// File: rtl/bru_pkg.sv
package bru_pkg;

  localparam int OPC_W = 6;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_EQ   = 3'd1,
    K_NE   = 3'd2,
    K_LT   = 3'd3,
    K_GT   = 3'd4,
    K_JMP  = 3'd5
  } ctl_kind_e;

  localparam logic [OPC_W-1:0] OPC_EQ  = 6'b100000;
  localparam logic [OPC_W-1:0] OPC_NE  = 6'b100001;
  localparam logic [OPC_W-1:0] OPC_LT  = 6'b100010;
  localparam logic [OPC_W-1:0] OPC_GT  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_JMP = 6'b100100;

  function automatic ctl_kind_e f_kind(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_EQ:  return K_EQ;
      OPC_NE:  return K_NE;
      OPC_LT:  return K_LT;
      OPC_GT:  return K_GT;
      OPC_JMP: return K_JMP;
      default: return K_NONE;
    endcase
  endfunction

endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] instr,
  output ctl_kind_e       kind,
  output logic            is_jump,
  output logic            is_cond
);
  logic [OPC_W-1:0] opc;
  assign opc     = instr[XLEN-1 -: OPC_W];
  assign kind    = f_kind(opc);
  assign is_jump = (kind == K_JMP);
  assign is_cond = (kind != K_NONE) && (kind != K_JMP);
endmodule

// File: rtl/bru_compare.sv
module bru_compare
  import bru_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  ctl_kind_e       kind,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            taken
);
  logic eq_w, lt_w, gt_w;
  assign eq_w = (opa == opb);
  assign lt_w = ($signed(opa) < $signed(opb));
  assign gt_w = ($signed(opa) > $signed(opb));

  always_comb begin
    case (kind)
      K_EQ:    taken = eq_w;
      K_NE:    taken = !eq_w;
      K_LT:    taken = lt_w;
      K_GT:    taken = gt_w;
      K_JMP:   taken = 1'b1;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_target.sv
module bru_target #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int JMP_W = 26
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] instr,
  input  logic            is_jump,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] target
);
  localparam int BR_PAD  = XLEN - IMM_W - 2;
  localparam int JMP_PAD = XLEN - JMP_W - 2;

  function automatic logic [XLEN-1:0] f_branch_off(input logic [IMM_W-1:0] imm);
    return {{BR_PAD{imm[IMM_W-1]}}, imm, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] f_jump_addr(input logic [JMP_W-1:0] fld);
    return {{JMP_PAD{1'b0}}, fld, 2'b00};
  endfunction

  assign seq_pc = pc + XLEN'(4);
  assign target = is_jump ? f_jump_addr(instr[JMP_W-1:0])
                          : seq_pc + f_branch_off(instr[IMM_W-1:0]);
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import bru_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int JMP_W = 26
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] in_instr,
  input  logic [XLEN-1:0] in_pc,
  input  logic [XLEN-1:0] in_opa,
  input  logic [XLEN-1:0] in_opb,
  input  logic            in_pred_taken,
  input  logic [XLEN-1:0] in_pred_target,
  output logic            out_valid,
  output logic [XLEN-1:0] out_pc,
  output logic            out_taken,
  output logic [XLEN-1:0] out_target,
  output logic [XLEN-1:0] out_next_pc,
  output logic            out_mispredict,
  output logic [XLEN-1:0] out_redirect_pc
);
  ctl_kind_e       kind;
  logic            is_jump, is_cond, taken;
  logic [XLEN-1:0] seq_pc, target;

  // named events for the checker
  logic            evt_accept, evt_dir_miss, evt_tgt_miss, evt_miss;
  logic [XLEN-1:0] next_pc;
  logic            q_jump;

  bru_decode #(.XLEN(XLEN)) dec_i (
    .instr(in_instr), .kind(kind), .is_jump(is_jump), .is_cond(is_cond)
  );

  bru_compare #(.XLEN(XLEN)) cmp_i (
    .kind(kind), .opa(in_opa), .opb(in_opb), .taken(taken)
  );

  bru_target #(.XLEN(XLEN), .IMM_W(IMM_W), .JMP_W(JMP_W)) tgt_i (
    .pc(in_pc), .instr(in_instr), .is_jump(is_jump),
    .seq_pc(seq_pc), .target(target)
  );

  assign evt_accept   = in_valid && (is_cond || is_jump);
  assign evt_dir_miss = taken != in_pred_taken;
  assign evt_tgt_miss = taken && in_pred_taken && (target != in_pred_target);
  assign evt_miss     = evt_dir_miss || evt_tgt_miss;
  assign next_pc      = taken ? target : seq_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_pc          <= '0;
      out_taken       <= 1'b0;
      out_target      <= '0;
      out_next_pc     <= '0;
      out_mispredict  <= 1'b0;
      out_redirect_pc <= '0;
      q_jump          <= 1'b0;
    end else begin
      out_valid <= evt_accept;
      if (evt_accept) begin
        out_pc          <= in_pc;
        out_taken       <= taken;
        out_target      <= target;
        out_next_pc     <= next_pc;
        out_mispredict  <= evt_miss;
        out_redirect_pc <= evt_miss ? next_pc : '0;
        q_jump          <= is_jump;
      end else begin
        out_mispredict  <= 1'b0;
        out_redirect_pc <= '0;
        q_jump          <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bru_checker.sv
module bru_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            evt_accept,
  input logic            out_valid,
  input logic [XLEN-1:0] out_pc,
  input logic            out_taken,
  input logic [XLEN-1:0] out_target,
  input logic [XLEN-1:0] out_next_pc,
  input logic            out_mispredict,
  input logic [XLEN-1:0] out_redirect_pc,
  input logic            q_jump
);
  assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> out_valid);
  assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_accept |=> !out_valid);
  assert_jump_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_jump) |-> out_taken);
  assert_next_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_taken) |-> (out_next_pc == out_target));
  assert_next_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_taken) |-> (out_next_pc == out_pc + XLEN'(4)));
  assert_miss_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_mispredict |-> out_valid);
  assert_redirect_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_mispredict |-> (out_redirect_pc == out_next_pc));
  assert_redirect_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_mispredict |-> (out_redirect_pc == '0));
endmodule

bind branch_resolve_unit bru_checker #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_accept(evt_accept), .out_valid(out_valid),
  .out_pc(out_pc), .out_taken(out_taken), .out_target(out_target),
  .out_next_pc(out_next_pc), .out_mispredict(out_mispredict),
  .out_redirect_pc(out_redirect_pc), .q_jump(q_jump)
);

// File: tb/branch_resolve_unit_tb.sv
module branch_resolve_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0, in_pc = '0, in_opa = '0, in_opb = '0;
  logic        in_pred_taken = 1'b0;
  logic [31:0] in_pred_target = '0;
  logic        out_valid, out_taken, out_mispredict;
  logic [31:0] out_pc, out_target, out_next_pc, out_redirect_pc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  branch_resolve_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_pc(in_pc), .in_opa(in_opa), .in_opb(in_opb),
    .in_pred_taken(in_pred_taken), .in_pred_target(in_pred_target),
    .out_valid(out_valid), .out_pc(out_pc), .out_taken(out_taken),
    .out_target(out_target), .out_next_pc(out_next_pc),
    .out_mispredict(out_mispredict), .out_redirect_pc(out_redirect_pc)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] mk_br(input logic [5:0] opc, input int off);
    return {opc, 5'd1, 5'd2, off[15:0]};
  endfunction

  function automatic logic [31:0] mk_j(input logic [25:0] fld);
    return {6'b100100, fld};
  endfunction

  // Drive at a falling edge, sample at the next falling edge; inputs stay driven.
  task automatic send(input string req, input logic [31:0] instr, input logic [31:0] pc,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic ptk, input logic [31:0] ptg);
    logic [5:0] opc;
    bit tk;
    longint tg;
    logic [31:0] nx;
    bit miss;
    in_valid = 1'b1; in_instr = instr; in_pc = pc; in_opa = a; in_opb = b;
    in_pred_taken = ptk; in_pred_target = ptg;
    opc = instr[31:26];
    tk = 0;
    if (opc == 6'b100000) tk = (a == b);
    if (opc == 6'b100001) tk = (a != b);
    if (opc == 6'b100010) tk = (int'(a) < int'(b));
    if (opc == 6'b100011) tk = (int'(a) > int'(b));
    if (opc == 6'b100100) begin
      tk = 1;
      tg = longint'(instr[25:0]) * 4;
    end else begin
      tg = longint'(pc) + 4 + longint'(int'(shortint'(instr[15:0]))) * 4;
    end
    nx = tk ? tg[31:0] : pc + 32'd4;
    miss = (tk != ptk) || (tk && ptk && (tg[31:0] != ptg));
    @(negedge clk);
    check(req, "valid", {31'd0, out_valid}, 32'd1);
    check("R11", "pc", out_pc, pc);
    check(req, "taken", {31'd0, out_taken}, {31'd0, tk});
    check(req, "target", out_target, tg[31:0]);
    check("R7", "next_pc", out_next_pc, nx);
    check(req, "mispredict", {31'd0, out_mispredict}, {31'd0, miss});
    check("R10", "redirect", out_redirect_pc, miss ? nx : 32'd0);
  endtask

  task automatic idle(input string req);
    in_valid = 1'b0;
    @(negedge clk);
    check(req, "valid idle", {31'd0, out_valid}, 32'd0);
    check("R10", "redirect idle", out_redirect_pc, 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R2", "valid in reset", {31'd0, out_valid}, 32'd0);
    check("R2", "mispredict in reset", {31'd0, out_mispredict}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", "valid after reset", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_equality; // R3
    send("R3", mk_br(6'b100000, 5), 32'h100, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1, 32'h118);
    send("R3", mk_br(6'b100000, 5), 32'h100, 32'hDEAD_BEEF, 32'hDEAD_BEEE, 1'b0, 32'h0);
    send("R3", mk_br(6'b100001, 3), 32'h200, 32'h1, 32'h8000_0001, 1'b1, 32'h210);
    send("R3", mk_br(6'b100001, 3), 32'h200, 32'h7, 32'h7, 1'b0, 32'h0);
    idle("R2");
  endtask

  task automatic t_signed; // R4
    send("R4", mk_br(6'b100010, 2), 32'h40, 32'hFFFF_FFFF, 32'h1, 1'b1, 32'h4C);
    send("R4", mk_br(6'b100010, 2), 32'h40, 32'h1, 32'hFFFF_FFFF, 1'b0, 32'h0);
    send("R4", mk_br(6'b100011, 2), 32'h40, 32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 32'h4C);
    send("R4", mk_br(6'b100011, 2), 32'h40, 32'h5, 32'h5, 1'b0, 32'h0);
    send("R4", mk_br(6'b100010, 2), 32'h40, 32'h5, 32'h5, 1'b0, 32'h0);
    idle("R2");
  endtask

  task automatic t_offsets; // R5
    send("R5", mk_br(6'b100000, -3), 32'h1000, 32'h0, 32'h0, 1'b1, 32'h0FF8);
    send("R5", mk_br(6'b100000, -32768), 32'h0001_0000, 32'h0, 32'h0, 1'b1, 32'h0);
    send("R5", mk_br(6'b100000, 32767), 32'hFFFF_FFF0, 32'h0, 32'h0, 1'b1, 32'h0);
    idle("R2");
  endtask

  task automatic t_jump; // R6
    send("R6", mk_j(26'h3FF_FFFF), 32'h8000_0000, 32'h0, 32'h1, 1'b1, 32'h0FFF_FFFC);
    send("R6", mk_j(26'h000_0010), 32'h500, 32'h0, 32'h0, 1'b0, 32'h0);
    idle("R2");
  endtask

  task automatic t_overlap; // R8 R9
    send("R8", mk_br(6'b100000, 8), 32'h300, 32'h1, 32'h2, 1'b1, 32'hBAD0);
    send("R9", mk_br(6'b100000, 8), 32'h300, 32'h1, 32'h1, 1'b1, 32'hBAD0);
    send("R9", mk_br(6'b100001, 8), 32'h300, 32'h1, 32'h1, 1'b0, 32'hBAD0);
    send("R9", mk_br(6'b100001, 8), 32'h300, 32'h1, 32'h2, 1'b1, 32'h324);
    idle("R2");
  endtask

  task automatic t_illegal; // R1
    in_valid = 1'b1; in_instr = {6'b100101, 26'h0}; in_pc = 32'h10;
    @(negedge clk);
    check("R1", "valid for unused opcode", {31'd0, out_valid}, 32'd0);
    in_instr = {6'b000000, 26'h0};
    @(negedge clk);
    check("R1", "valid for arithmetic opcode", {31'd0, out_valid}, 32'd0);
    idle("R1");
  endtask

  initial begin
    t_reset();
    t_equality();
    t_signed();
    t_offsets();
    t_jump();
    t_overlap();
    t_illegal();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule